// File: doc/BRIEF.md
# Priority-Arbitrated Shared Bus

This block is one shared data path between several bus masters and a set of memory-mapped slave memories. Each master raises a level request together with a direction flag, a start address, a beat count and a lock flag. The bus registers that request, grants one master at a time by fixed priority, and moves the burst one word per beat. Each slave has its own address window and its own number of wait states. Read data and the per-beat strobe go back on a shared return path. Each master sees a 3-bit status that it can poll at any time.

The master index is also its priority, with index 0 the highest, so the index is the master's identity on the bus. A master that finishes a transfer with its lock flag set keeps the bus until it drops the flag or stops requesting. A debug port reads and writes the slave memories at once through the same address map. It does not take part in arbitration and does not touch any master's status.

Top module: `prio_bus`

## Requirements
- R1: After reset every master status is IDLE (code 0) and no beat strobe is high.
- R2: A request seen at a rising edge moves that master's status to PEND (code 1) at that edge. The grant, which moves the status to BUSY (code 2), happens at the next edge at the earliest. A beat strobe is only ever given to the master that is BUSY.
- R3: When several masters are PEND and the bus is free and unlocked, the master with the lowest index is granted. At most one master is BUSY at any time.
- R4: When a master completes a transfer with its lock flag set, the bus waits for that master and grants it again ahead of any higher-priority PEND master. This lasts while its lock flag stays high and it does not leave its request low in an idle status. Once the lock flag drops, the next arbitration is by priority again.
- R5: Slave s decodes the inclusive window s*STRIDE to s*STRIDE+WIN-1. With the default parameters these are 0..15 and 32..47. A read returns the word last written at that address.
- R6: A burst moves the count given on the length field, with count 0 treated as 1. The address steps by one per beat, and exactly one beat strobe pulse is given per beat.
- R7: Slave s adds s*WSTEP wait cycles before every beat. A zero-wait slave completes its beat in the first cycle it is selected. A clean transfer therefore reaches DONE (code 3) 2 + len*(1+wait) cycles after the request is raised.
- R8: A transfer whose start address lies in no window ends with ERR (code 4) in its first active cycle. It gives no beat and changes no memory word.
- R9: A burst that runs past the end of its slave's window completes the beats inside the window. It then ends with ERR at the first out-of-window beat, which writes nothing.
- R10: The debug port returns the addressed word combinationally and writes at the next edge. It flags unmapped addresses on its error output, and it leaves every master status unchanged.
- R11: DONE or ERR is held while the master keeps its request high. The status returns to IDLE one edge after the request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | NM | Per-master request level |
| m_wr | input | NM | Per-master direction, 1 = write |
| m_lock | input | NM | Per-master lock flag |
| m_addr | input | NM*AW | Per-master start address, master i at bits i*AW |
| m_len | input | NM*LW | Per-master beat count, 0 means 1 |
| m_wdata | input | NM*DW | Per-master write data for the current beat |
| m_rdata | output | DW | Read data during a read beat |
| m_beat | output | NM | One-hot beat strobe to the owning master |
| m_stat | output | NM*3 | Per-master status: 0 IDLE, 1 PEND, 2 BUSY, 3 DONE, 4 ERR |
| dbg_en | input | 1 | Debug access enable |
| dbg_wr | input | 1 | Debug direction, 1 = write |
| dbg_addr | input | AW | Debug address |
| dbg_wdata | input | DW | Debug write data |
| dbg_rdata | output | DW | Debug read data |
| dbg_err | output | 1 | Debug address is unmapped |

## Verification
The bench builds the block with three masters, two slaves of 16 words at a stride of 32, an 8-bit address and 2 wait states per slave step. Slave 0 therefore has no wait states and slave 1 has two. This leaves a hole at 16..31 and unmapped space above 48, so both error paths are reachable. The bench sweeps every burst length from 1 to 4 on both slaves, for writes and reads. Transfer duration and data are predicted from the window and wait arithmetic. Directed sequences then cover priority order, the lock hold and release, and bursts that cross the end of each window.

// File: rtl/prio_bus.sv
module prio_bus #(
  parameter int NM     = 3,
  parameter int NS     = 2,
  parameter int AW     = 8,
  parameter int DW     = 16,
  parameter int LW     = 4,
  parameter int WIN    = 16,
  parameter int STRIDE = 32,
  parameter int WSTEP  = 2,
  parameter int WCW    = 4
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    m_req,
  input  logic [NM-1:0]    m_wr,
  input  logic [NM-1:0]    m_lock,
  input  logic [NM*AW-1:0] m_addr,
  input  logic [NM*LW-1:0] m_len,
  input  logic [NM*DW-1:0] m_wdata,
  output logic [DW-1:0]    m_rdata,
  output logic [NM-1:0]    m_beat,
  output logic [NM*3-1:0]  m_stat,
  input  logic             dbg_en,
  input  logic             dbg_wr,
  input  logic [AW-1:0]    dbg_addr,
  input  logic [DW-1:0]    dbg_wdata,
  output logic [DW-1:0]    dbg_rdata,
  output logic             dbg_err
);

  localparam int SB    = $clog2(STRIDE);
  localparam int SW    = AW - SB;
  localparam int DEPTH = NS * WIN;
  localparam int IW    = $clog2(DEPTH);
  localparam int IDW   = (NM > 1) ? $clog2(NM) : 1;

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_PEND = 3'd1;
  localparam logic [2:0] S_BUSY = 3'd2;
  localparam logic [2:0] S_DONE = 3'd3;
  localparam logic [2:0] S_ERR  = 3'd4;

  function automatic logic mapped(input logic [AW-1:0] a);
    return (int'(a[AW-1:SB]) < NS) && (int'(a[SB-1:0]) < WIN);
  endfunction

  function automatic logic [IW-1:0] word_idx(input logic [AW-1:0] a);
    int t;
    t = int'(a[AW-1:SB]) * WIN + int'(a[SB-1:0]);
    return t[IW-1:0];
  endfunction

  logic [DW-1:0]  mem [DEPTH];
  logic [2:0]     st [NM];
  logic [NM-1:0]  pend;

  logic           act, wr_q, lk_q;
  logic [IDW-1:0] owner;
  logic [AW-1:0]  cur;
  logic [SW-1:0]  bslv;
  logic [LW-1:0]  rem;
  logic [WCW-1:0] wcnt, wt;

  logic           lock_v;
  logic [IDW-1:0] lock_id;
  logic           hold, gv;
  logic [IDW-1:0] gid;
  logic           ok, err, beat, fin;
  logic [AW-1:0]  g_addr;
  logic [LW-1:0]  g_len;

  assign ok   = act && (cur[AW-1:SB] == bslv) && (int'(bslv) < NS) && (int'(cur[SB-1:0]) < WIN);
  assign err  = act && !ok;
  assign wt   = WCW'(int'(cur[AW-1:SB]) * WSTEP);
  assign beat = ok && (wcnt == wt);
  assign fin  = err || (beat && rem == LW'(1));

  assign g_addr = m_addr[gid*AW +: AW];
  assign g_len  = m_len[gid*LW +: LW];

  always_comb begin
    for (int i = 0; i < NM; i++) pend[i] = (st[i] == S_PEND);
    hold = lock_v && m_lock[lock_id] && !(st[lock_id] == S_IDLE && !m_req[lock_id]);
    gv  = 1'b0;
    gid = '0;
    if (!act) begin
      if (hold) begin
        gv  = pend[lock_id];
        gid = lock_id;
      end else begin
        for (int i = NM - 1; i >= 0; i--) begin
          if (pend[i]) begin
            gv  = 1'b1;
            gid = IDW'(i);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act     <= 1'b0;
      wr_q    <= 1'b0;
      lk_q    <= 1'b0;
      owner   <= '0;
      cur     <= '0;
      bslv    <= '0;
      rem     <= '0;
      wcnt    <= '0;
      lock_v  <= 1'b0;
      lock_id <= '0;
    end else begin
      if (gv) begin
        act   <= 1'b1;
        owner <= gid;
        wr_q  <= m_wr[gid];
        lk_q  <= m_lock[gid];
        cur   <= g_addr;
        bslv  <= g_addr[AW-1:SB];
        rem   <= (g_len == '0) ? LW'(1) : g_len;
        wcnt  <= '0;
      end else if (act) begin
        if (fin) begin
          act     <= 1'b0;
          lock_v  <= lk_q;
          lock_id <= owner;
        end else if (beat) begin
          cur  <= cur + AW'(1);
          rem  <= rem - LW'(1);
          wcnt <= '0;
        end else begin
          wcnt <= wcnt + WCW'(1);
        end
      end
      if (!act && !hold) lock_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NM; i++) st[i] <= S_IDLE;
    end else begin
      for (int i = 0; i < NM; i++) begin
        if (fin && owner == IDW'(i))
          st[i] <= err ? S_ERR : S_DONE;
        else if (gv && gid == IDW'(i))
          st[i] <= S_BUSY;
        else begin
          case (st[i])
            S_IDLE:                 if (m_req[i])  st[i] <= S_PEND;
            S_PEND, S_DONE, S_ERR:  if (!m_req[i]) st[i] <= S_IDLE;
            default:                st[i] <= st[i];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (beat && wr_q)
      mem[word_idx(cur)] <= m_wdata[owner*DW +: DW];
    if (dbg_en && dbg_wr && mapped(dbg_addr))
      mem[word_idx(dbg_addr)] <= dbg_wdata;
  end

  assign m_rdata   = (beat && !wr_q) ? mem[word_idx(cur)] : '0;
  assign dbg_rdata = (dbg_en && mapped(dbg_addr)) ? mem[word_idx(dbg_addr)] : '0;
  assign dbg_err   = dbg_en && !mapped(dbg_addr);

  always_comb begin
    for (int i = 0; i < NM; i++) m_beat[i] = beat && (owner == IDW'(i));
  end

  generate
    for (genvar i = 0; i < NM; i++) begin : g_stat
      assign m_stat[i*3 +: 3] = st[i];
    end
  endgenerate

endmodule

// File: rtl/prio_bus_chk.sv
module prio_bus_chk #(
  parameter int NM = 3
)(
  input logic            clk,
  input logic            rst_n,
  input logic [NM*3-1:0] m_stat,
  input logic [NM-1:0]   m_beat
);

  logic [NM-1:0] busy;
  always_comb begin
    for (int i = 0; i < NM; i++) busy[i] = (m_stat[i*3 +: 3] == 3'd2);
  end

  // R3
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(busy) <= 1);

  // R6
  beat_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_beat));

  // R2
  beat_to_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_beat & ~busy) == '0);

  generate
    for (genvar i = 0; i < NM; i++) begin : g_seq
      // R11
      busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy[i] |=> (m_stat[i*3 +: 3] inside {3'd2, 3'd3, 3'd4}));
      // R2
      pend_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_stat[i*3 +: 3] == 3'd1) |=> (m_stat[i*3 +: 3] inside {3'd0, 3'd1, 3'd2}));
    end
  endgenerate

endmodule

bind prio_bus prio_bus_chk #(.NM(NM)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .m_stat(m_stat),
  .m_beat(m_beat)
);

// File: tb/prio_bus_test.sv
`timescale 1ns/1ps
module prio_bus_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  m_req = '0, m_wr = '0, m_lock = '0;
  logic [7:0]  ma [3];
  logic [3:0]  ml [3];
  logic [15:0] mw [3];
  logic [23:0] m_addr;
  logic [11:0] m_len;
  logic [47:0] m_wdata;
  logic [15:0] m_rdata;
  logic [2:0]  m_beat;
  logic [8:0]  m_stat;
  logic        dbg_en = 1'b0, dbg_wr = 1'b0;
  logic [7:0]  dbg_addr = '0;
  logic [15:0] dbg_wdata = '0;
  logic [15:0] dbg_rdata;
  logic        dbg_err;

  assign m_addr  = {ma[2], ma[1], ma[0]};
  assign m_len   = {ml[2], ml[1], ml[0]};
  assign m_wdata = {mw[2], mw[1], mw[0]};

  prio_bus uut (
    .clk(clk), .rst_n(rst_n),
    .m_req(m_req), .m_wr(m_wr), .m_lock(m_lock),
    .m_addr(m_addr), .m_len(m_len), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_beat(m_beat), .m_stat(m_stat),
    .dbg_en(dbg_en), .dbg_wr(dbg_wr), .dbg_addr(dbg_addr),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .dbg_err(dbg_err)
  );

  int checks = 0;
  int fails  = 0;
  int rd [16];

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int stat(input int mi);
    return int'(m_stat[mi*3 +: 3]);
  endfunction

  task automatic setm(input int mi, input bit req, input bit wr, input int a, input int n, input bit lk);
    m_req[mi]  = req;
    m_wr[mi]   = wr;
    m_lock[mi] = lk;
    ma[mi]     = 8'(a);
    ml[mi]     = 4'(n);
  endtask

  task automatic xfer(input int mi, input bit wr, input int a, input int n, input int base,
                      output int nb, output int cyc, output int fst);
    @(negedge clk);
    setm(mi, 1'b1, wr, a, n, 1'b0);
    mw[mi] = 16'(base);
    nb = 0; cyc = 0; fst = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      cyc++;
      mw[mi] = 16'(base + nb);
      if (m_beat[mi]) begin
        if (!wr) rd[nb] = int'(m_rdata);
        nb++;
      end
      fst = stat(mi);
      if (fst == 3 || fst == 4) break;
    end
    @(negedge clk);
    chk(stat(mi) == fst, "R11 held", stat(mi), fst);
    m_req[mi] = 1'b0;
    @(negedge clk);
    chk(stat(mi) == 0, "R11 idle", stat(mi), 0);
  endtask

  task automatic dread(input int a, output int v);
    dbg_en = 1'b1; dbg_wr = 1'b0; dbg_addr = 8'(a);
    #1;
    v = int'(dbg_rdata);
    dbg_en = 1'b0;
  endtask

  task automatic dwrite(input int a, input int v);
    @(negedge clk);
    dbg_en = 1'b1; dbg_wr = 1'b1; dbg_addr = 8'(a); dbg_wdata = 16'(v);
    @(negedge clk);
    dbg_en = 1'b0; dbg_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int nb, cyc, fst, v, w, base, a;
    for (int i = 0; i < 3; i++) begin ma[i] = '0; ml[i] = '0; mw[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(m_stat == '0, "R1 status", int'(m_stat), 0);
    chk(m_beat == '0, "R1 beat", int'(m_beat), 0);

    // R5 R6 R7: sweep both slaves, all lengths, write then read
    for (int s = 0; s < 2; s++) begin
      for (int n = 1; n <= 4; n++) begin
        w = 2 * s;
        a = 32 * s + n;
        base = 100 * s + 10 * n;
        xfer(0, 1'b1, a, n, base, nb, cyc, fst);
        chk(fst == 3, "R7 write done", fst, 3);
        chk(nb == n, "R6 write beats", nb, n);
        chk(cyc == 2 + n * (1 + w), "R7 write cycles", cyc, 2 + n * (1 + w));
        xfer(1, 1'b0, a, n, 0, nb, cyc, fst);
        chk(fst == 3, "R7 read done", fst, 3);
        chk(nb == n, "R6 read beats", nb, n);
        chk(cyc == 2 + n * (1 + w), "R7 read cycles", cyc, 2 + n * (1 + w));
        for (int k = 0; k < n; k++) begin
          chk(rd[k] == base + k, "R5 read data", rd[k], base + k);
          dread(a + k, v);
          chk(v == base + k, "R10 debug read", v, base + k);
        end
      end
    end

    // R6: length 0 moves one word
    xfer(2, 1'b1, 33, 0, 500, nb, cyc, fst);
    chk(nb == 1 && fst == 3, "R6 len0 beats", nb, 1);
    chk(cyc == 5, "R6 len0 cycles", cyc, 5);
    dread(33, v); chk(v == 500, "R6 len0 data", v, 500);
    dread(34, v); chk(v == 120, "R6 len0 next word", v, 120);

    // R8: unmapped start
    xfer(0, 1'b1, 20, 2, 900, nb, cyc, fst);
    chk(fst == 4, "R8 err", fst, 4);
    chk(nb == 0, "R8 beats", nb, 0);
    chk(cyc == 3, "R8 cycles", cyc, 3);
    dread(36, v); chk(v == 140, "R8 no write s1", v, 140);
    dread(4, v);  chk(v == 40, "R8 no write s0", v, 40);
    xfer(1, 1'b0, 70, 1, 0, nb, cyc, fst);
    chk(fst == 4 && nb == 0, "R8 err high", fst, 4);

    // R10: debug write, readback, error flag, no status effect
    dwrite(0, 77);
    dread(0, v); chk(v == 77, "R10 write", v, 77);
    chk(m_stat == '0, "R10 status", int'(m_stat), 0);
    dbg_en = 1'b1; dbg_addr = 8'd20; #1;
    chk(dbg_err == 1'b1, "R10 unmapped flag", int'(dbg_err), 1);
    dbg_addr = 8'd2; #1;
    chk(dbg_err == 1'b0, "R10 mapped flag", int'(dbg_err), 0);
    dbg_en = 1'b0;

    // R9: bursts crossing window ends
    xfer(0, 1'b1, 14, 4, 700, nb, cyc, fst);
    chk(fst == 4 && nb == 2, "R9 s0 beats", nb, 2);
    chk(cyc == 5, "R9 s0 cycles", cyc, 5);
    dread(14, v); chk(v == 700, "R9 word14", v, 700);
    dread(15, v); chk(v == 701, "R9 word15", v, 701);
    dread(0, v);  chk(v == 77, "R9 no wrap", v, 77);
    xfer(2, 1'b1, 46, 3, 800, nb, cyc, fst);
    chk(fst == 4 && nb == 2, "R9 s1 beats", nb, 2);
    chk(cyc == 9, "R9 s1 cycles", cyc, 9);
    dread(47, v); chk(v == 801, "R9 word47", v, 801);

    // R2 R3: simultaneous requests
    @(negedge clk);
    setm(1, 1'b1, 1'b0, 32, 1, 1'b0);
    setm(2, 1'b1, 1'b0, 33, 1, 1'b0);
    @(negedge clk);
    chk(stat(1) == 1 && stat(2) == 1, "R2 pend", stat(1), 1);
    @(negedge clk);
    chk(stat(1) == 2, "R3 winner busy", stat(1), 2);
    chk(stat(2) == 1, "R3 loser pend", stat(2), 1);
    repeat (3) @(negedge clk);
    chk(stat(1) == 3, "R7 first done", stat(1), 3);
    m_req[1] = 1'b0;
    @(negedge clk);
    chk(stat(2) == 2, "R3 second busy", stat(2), 2);
    repeat (3) @(negedge clk);
    chk(stat(2) == 3, "R3 second done", stat(2), 3);
    m_req[2] = 1'b0;
    repeat (2) @(negedge clk);

    // R4: lock holds the bus against a higher priority master
    setm(2, 1'b1, 1'b0, 3, 1, 1'b1);
    repeat (2) @(negedge clk);
    chk(stat(2) == 2, "R4 locked busy", stat(2), 2);
    @(negedge clk);
    chk(stat(2) == 3, "R4 locked done", stat(2), 3);
    m_req[2] = 1'b0;
    setm(0, 1'b1, 1'b0, 5, 1, 1'b0);
    @(negedge clk);
    chk(stat(0) == 1, "R4 high pend", stat(0), 1);
    m_req[2] = 1'b1;
    @(negedge clk);
    chk(stat(0) == 1, "R4 high waits", stat(0), 1);
    @(negedge clk);
    chk(stat(2) == 2, "R4 regrant", stat(2), 2);
    chk(stat(0) == 1, "R4 high still waits", stat(0), 1);
    @(negedge clk);
    chk(stat(2) == 3, "R4 second done", stat(2), 3);
    m_req[2] = 1'b0; m_lock[2] = 1'b0;
    @(negedge clk);
    chk(stat(0) == 2, "R4 release", stat(0), 2);
    @(negedge clk);
    m_req[0] = 1'b0;
    repeat (2) @(negedge clk);
    chk(m_stat == '0, "R11 all idle", int'(m_stat), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule